// File: doc/BRIEF.md
# Incremental Encoder Position Decoder

This block turns the two phase outputs and the index output of an incremental shaft encoder into a signed position count. It counts four times per encoder cycle, once on every edge of either phase. The encoder inputs are never used as clocks. They are resampled by the system clock through a short synchronizer chain. A register keeps the last sampled phase pair, and each new sample is classified against it as one step forward, one step back, no movement, or an illegal jump in which both phases changed together.

Legal steps drive an up/down position counter that wraps on overflow. Contact chatter on one phase is followed, not filtered: the count moves back and forth with the bounce and ends at the right value once the input settles. An illegal jump leaves the count unchanged. It sets a sticky error flag and advances a saturating error-event counter, and both stay until the clear input is asserted. The first index pulse after reset zeroes the position, and later index pulses are ignored. The system clock must sample faster than the fastest legitimate phase change.

Top module: `quad_decoder`

## Requirements
- R1: With the phase pair written as {enc_a, enc_b}, the forward order is 00, 01, 11, 10, 00. Each single-bit change in that order adds one to `position`.
- R2: Each single-bit change in the reverse order (00, 10, 11, 01, 00) subtracts one from `position`.
- R3: Consider an input change made between clock edges. `step_en` is high for exactly one cycle after the second rising edge that follows the change, and `step_up` is 1 for a forward step and 0 for a backward step. `position`, `err_sticky` and `err_count` take their new values on the third rising edge. (Both figures hold with the default of two synchronizer stages.)
- R4: A sample in which both phase bits differ from the previous sample pulses `jump_err` for one cycle with `step_en` low and leaves `position` unchanged.
- R5: Chatter on one phase is tracked. Toggling a phase forward, back and forward again gives +1, -1, +1, so the net change is +1.
- R6: The first rising edge of `enc_idx` after reset sets `position` to 0. Later rising edges of `enc_idx` leave `position` unchanged.
- R7: `err_sticky` goes to 1 on an illegal jump and stays at 1 across later legal steps until `err_clr` is high at a rising edge. `err_clr` clears it on that edge.
- R8: `err_count` adds one per illegal jump, stops at 2^ERR_W-1, and is zeroed by `err_clr`.
- R9: `position` is a POS_W-bit two's-complement value. One step up from the largest positive value gives the most negative value.
- R10: While `rst_n` is low at a clock edge, `position`, `err_sticky`, `err_count` and `step_en` are 0. The first sample after reset only loads the previous-phase register: it produces no step and no error, whatever the phase pair is.
- R11: A sample equal to the previous sample produces neither `step_en` nor `jump_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Raw encoder phase A (MSB of the phase pair) |
| enc_b | input | 1 | Raw encoder phase B (LSB of the phase pair) |
| enc_idx | input | 1 | Raw encoder index |
| err_clr | input | 1 | Clears the error flag and the error-event counter |
| position | output | POS_W | Signed position count, wraps on overflow |
| step_en | output | 1 | One-cycle pulse per legal step |
| step_up | output | 1 | Direction of the current step: 1 forward, 0 backward |
| jump_err | output | 1 | One-cycle pulse per illegal double-bit jump |
| err_sticky | output | 1 | Latched illegal-jump flag |
| err_count | output | ERR_W | Saturating count of illegal jumps |

## Verification
After a phase change, the step and jump pulses are due two rising edges later and last one cycle. Position and both error results are due on the third edge, and a clear acts on the first edge after `err_clr`. When the driver task applies a stimulus, it stamps each expected result with the exact cycle in which that result is due. The monitor compares a result at the falling edge of that cycle and never at any other time. The driver holds every stimulus for four cycles, so the expected results of successive stimuli never overlap and the queue stays in due-cycle order.

// File: rtl/qd_pkg.sv
// Package: shared types for the encoder position decoder.
// Assumes the phase pair is ordered {A, B} with A in the MSB.
package qd_pkg;

    // Sampled phase pair {A, B}
    typedef logic [1:0] phase_t;

    // Classification of one sample against the previous one
    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_FWD  = 2'd1,
        MOVE_BACK = 2'd2,
        MOVE_JUMP = 2'd3
    } move_e;

    // Map a previous/current phase pair onto a movement; all 16 cases listed
    function automatic move_e classify(input phase_t prev, input phase_t cur);
        move_e m;
        case ({prev, cur})
            4'b0001, 4'b0111, 4'b1110, 4'b1000: m = MOVE_FWD;
            4'b0010, 4'b1011, 4'b1101, 4'b0100: m = MOVE_BACK;
            4'b0011, 4'b1100, 4'b0110, 4'b1001: m = MOVE_JUMP;
            default:                            m = MOVE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/qd_sync.sv
// Module: qd_sync
// Resamples WIDTH asynchronous inputs into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 2. The chain is not reset,
// so it keeps following the inputs while reset is held.
module qd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the raw inputs along the synchronizer chain
    always_ff @(posedge clk) begin
        chain_q[0] <= din;
        for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/qd_transition.sv
// Module: qd_transition
// Keeps the previous sampled phase pair and classifies each new sample
// against it. Outputs are combinational from registered state. Assumes
// the phase input is already synchronous. The first sample after reset
// is loaded without being classified.
module qd_transition
    import qd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    output logic   step_en,
    output logic   step_up,
    output logic   jump_err
);

    phase_t prev_q;
    logic   armed_q;
    move_e  move;

    // Track the previous phase pair and note that it is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= phase;
            armed_q <= 1'b1;
        end
    end

    // Classify the current sample against the stored one
    always_comb begin
        move = armed_q ? classify(prev_q, phase) : MOVE_NONE;
        step_en  = (move == MOVE_FWD) || (move == MOVE_BACK);
        step_up  = (move == MOVE_FWD);
        jump_err = (move == MOVE_JUMP);
    end

endmodule

// File: rtl/qd_position.sv
// Module: qd_position
// Up/down position counter of POS_W bits that wraps on overflow. It is
// zeroed by the first synchronized index rising edge after reset; later
// index edges are ignored. An index clear takes priority over a step
// in the same cycle.
module qd_position #(
    parameter int POS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic                    step_up,
    input  logic                    idx_level,
    output logic signed [POS_W-1:0] position,
    output logic                    idx_clear,
    output logic                    idx_seen
);

    localparam logic signed [POS_W-1:0] POS_ONE = POS_W'(1);

    logic signed [POS_W-1:0] pos_q;
    logic                    idx_q;
    logic                    seen_q;

    // First index rising edge since reset
    assign idx_clear = idx_level && !idx_q && !seen_q;

    // Index edge history and once-only latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            idx_q <= idx_level;
            if (idx_clear) begin
                seen_q <= 1'b1;
            end
        end
    end

    // Position counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (idx_clear) begin
            pos_q <= '0;
        end else if (step_en) begin
            pos_q <= step_up ? (pos_q + POS_ONE) : (pos_q - POS_ONE);
        end
    end

    assign position = pos_q;
    assign idx_seen = seen_q;

endmodule

// File: rtl/qd_error.sv
// Module: qd_error
// Sticky illegal-jump flag and saturating event counter of ERR_W bits.
// A clear restarts both from this cycle's event, so an event that
// coincides with a clear is not lost.
module qd_error #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             jump_err,
    input  logic             err_clr,
    output logic             err_sticky,
    output logic [ERR_W-1:0] err_count
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;
    localparam logic [ERR_W-1:0] CNT_ONE = ERR_W'(1);

    logic             flag_q;
    logic [ERR_W-1:0] cnt_q;

    // Latch the flag and count events up to saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else if (err_clr) begin
            flag_q <= jump_err;
            cnt_q  <= jump_err ? CNT_ONE : '0;
        end else if (jump_err) begin
            flag_q <= 1'b1;
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end
    end

    assign err_sticky = flag_q;
    assign err_count  = cnt_q;

endmodule

// File: rtl/quad_decoder.sv
// Module: quad_decoder
// Top level of the 4x encoder position decoder. Synchronizes the phase
// and index inputs, classifies phase transitions, and drives the
// position counter and the error tracking. Assumes the clock is faster
// than the fastest legitimate phase change.
module quad_decoder #(
    parameter int POS_W       = 16,
    parameter int ERR_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic                    enc_idx,
    input  logic                    err_clr,
    output logic signed [POS_W-1:0] position,
    output logic                    step_en,
    output logic                    step_up,
    output logic                    jump_err,
    output logic                    err_sticky,
    output logic [ERR_W-1:0]        err_count
);

    logic [2:0] raw_in;
    logic [2:0] sync_in;
    logic       idx_clear;
    logic       idx_seen;

    assign raw_in = {enc_a, enc_b, enc_idx};

    qd_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .din  (raw_in),
        .dout (sync_in)
    );

    qd_transition u_trans (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (sync_in[2:1]),
        .step_en  (step_en),
        .step_up  (step_up),
        .jump_err (jump_err)
    );

    qd_position #(
        .POS_W (POS_W)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .step_up   (step_up),
        .idx_level (sync_in[0]),
        .position  (position),
        .idx_clear (idx_clear),
        .idx_seen  (idx_seen)
    );

    qd_error #(
        .ERR_W (ERR_W)
    ) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .jump_err   (jump_err),
        .err_clr    (err_clr),
        .err_sticky (err_sticky),
        .err_count  (err_count)
    );

endmodule

// File: rtl/qd_checker.sv
// Module: qd_checker
// Temporal properties of quad_decoder, attached to it by bind.
module qd_checker #(
    parameter int POS_W = 16,
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_clr,
    input logic [POS_W-1:0] position,
    input logic             step_en,
    input logic             step_up,
    input logic             jump_err,
    input logic             err_sticky,
    input logic [ERR_W-1:0] err_count,
    input logic             idx_clear,
    input logic             idx_seen
);

    localparam logic [POS_W-1:0] P_ONE   = POS_W'(1);
    localparam logic [ERR_W-1:0] C_MAX   = '1;

    AST_STEP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !idx_clear) |=> (position == $past(position) + P_ONE)); // R1

    AST_STEP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !idx_clear) |=> (position == $past(position) - P_ONE)); // R2

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_en, jump_err})); // R4

    AST_JUMP_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_err && !idx_clear) |=> $stable(position)); // R4

    AST_FIRST_INDEX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clear |-> !idx_seen); // R6

    AST_INDEX_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clear |=> (position == '0)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clr) |=> err_sticky); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == C_MAX && !err_clr) |=> (err_count == C_MAX)); // R8

endmodule

bind quad_decoder qd_checker #(
    .POS_W (POS_W),
    .ERR_W (ERR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_clr    (err_clr),
    .position   (position),
    .step_en    (step_en),
    .step_up    (step_up),
    .jump_err   (jump_err),
    .err_sticky (err_sticky),
    .err_count  (err_count),
    .idx_clear  (idx_clear),
    .idx_seen   (idx_seen)
);

// File: tb/quad_decoder_tb.sv
`timescale 1ns/1ps
module quad_decoder_tb;

    localparam int PW = 8;
    localparam int EW = 4;
    localparam int CMAX = (1 << EW) - 1;

    localparam int K_POS = 0;
    localparam int K_EN  = 1;
    localparam int K_UP  = 2;
    localparam int K_JMP = 3;
    localparam int K_ERR = 4;
    localparam int K_CNT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b1;
    logic enc_b = 1'b1;
    logic enc_idx = 1'b0;
    logic err_clr = 1'b0;
    logic signed [PW-1:0] position;
    logic step_en, step_up, jump_err, err_sticky;
    logic [EW-1:0] err_count;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int     q_due[$];
    int     q_kind[$];
    longint q_exp[$];
    string  q_req[$];

    logic [1:0] m_prev = 2'b11;
    longint     m_pos = 0;
    bit         m_err = 1'b0;
    int         m_cnt = 0;
    bit         m_seen = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_decoder #(.POS_W(PW), .ERR_W(EW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .enc_idx(enc_idx), .err_clr(err_clr), .position(position),
        .step_en(step_en), .step_up(step_up), .jump_err(jump_err),
        .err_sticky(err_sticky), .err_count(err_count)
    );

    function automatic longint actual(input int kind);
        case (kind)
            K_POS:   return longint'(position);
            K_EN:    return longint'(step_en);
            K_UP:    return longint'(step_up);
            K_JMP:   return longint'(jump_err);
            K_ERR:   return longint'(err_sticky);
            default: return longint'(err_count);
        endcase
    endfunction

    function automatic string kname(input int kind);
        case (kind)
            K_POS:   return "position";
            K_EN:    return "step_en";
            K_UP:    return "step_up";
            K_JMP:   return "jump_err";
            K_ERR:   return "err_sticky";
            default: return "err_count";
        endcase
    endfunction

    task automatic check_now(input int kind, input longint exp, input string req);
        longint act;
        act = actual(kind);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, kname(kind), cyc, act, exp);
        end
    endtask

    function automatic void push(input int due, input int kind, input longint exp, input string req);
        q_due.push_back(due);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_req.push_back(req);
    endfunction

    // Monitor: compare each expected item in the cycle it is due
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            if (q_due[0] < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s %s missed at cycle %0d: actual %0d expected %0d",
                         q_req[0], kname(q_kind[0]), cyc, actual(q_kind[0]), q_exp[0]);
            end else begin
                check_now(q_kind[0], q_exp[0], q_req[0]);
            end
            void'(q_due.pop_front());
            void'(q_kind.pop_front());
            void'(q_exp.pop_front());
            void'(q_req.pop_front());
        end
    end

    function automatic int gray_pos(input logic [1:0] p);
        case (p)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    function automatic longint wrap(input longint v);
        longint w;
        w = v & ((longint'(1) << PW) - 1);
        if (w >= (longint'(1) << (PW - 1))) w = w - (longint'(1) << PW);
        return w;
    endfunction

    // Driver: apply one phase pair and queue the results it must produce
    task automatic drive_phase(input logic a, input logic b, input string req);
        int d;
        @(negedge clk);
        d = (gray_pos({a, b}) - gray_pos(m_prev) + 4) % 4;
        if (d == 1) m_pos = wrap(m_pos + 1);
        if (d == 3) m_pos = wrap(m_pos - 1);
        if (d == 2) begin
            m_err = 1'b1;
            if (m_cnt < CMAX) m_cnt++;
        end
        m_prev = {a, b};
        enc_a = a;
        enc_b = b;
        push(cyc + 2, K_EN, (d == 1 || d == 3) ? 1 : 0, req);
        if (d == 1 || d == 3) push(cyc + 2, K_UP, (d == 1) ? 1 : 0, req);
        push(cyc + 2, K_JMP, (d == 2) ? 1 : 0, req);
        push(cyc + 3, K_POS, m_pos, req);
        push(cyc + 3, K_ERR, m_err, req);
        push(cyc + 3, K_CNT, m_cnt, req);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_index(input string req);
        @(negedge clk);
        enc_idx = 1'b1;
        if (!m_seen) begin
            m_seen = 1'b1;
            m_pos = 0;
        end
        push(cyc + 3, K_POS, m_pos, req);
        repeat (3) @(negedge clk);
        @(negedge clk);
        enc_idx = 1'b0;
        push(cyc + 3, K_POS, m_pos, req);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_errors(input string req);
        @(negedge clk);
        err_clr = 1'b1;
        m_err = 1'b0;
        m_cnt = 0;
        push(cyc + 1, K_ERR, 0, req);
        push(cyc + 1, K_CNT, 0, req);
        @(negedge clk);
        err_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        finish_run();
    end

    initial begin
        // R10: reset state with phase pair 11 held at the inputs
        repeat (6) @(negedge clk);
        check_now(K_POS, 0, "R10");
        check_now(K_ERR, 0, "R10");
        check_now(K_CNT, 0, "R10");
        check_now(K_EN, 0, "R10");
        rst_n = 1'b1;
        // R10: the first sample after reset loads without stepping or erroring
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_now(K_EN, 0, "R10");
            check_now(K_JMP, 0, "R10");
        end
        check_now(K_POS, 0, "R10");
        check_now(K_ERR, 0, "R10");

        // R1: forward sequence from 11
        drive_phase(1'b1, 1'b0, "R1");
        drive_phase(1'b0, 1'b0, "R1");
        drive_phase(1'b0, 1'b1, "R1");
        drive_phase(1'b1, 1'b1, "R1");
        // R2: reverse sequence
        drive_phase(1'b0, 1'b1, "R2");
        drive_phase(1'b0, 1'b0, "R2");
        drive_phase(1'b1, 1'b0, "R2");
        drive_phase(1'b1, 1'b1, "R2");
        drive_phase(1'b0, 1'b1, "R2");
        drive_phase(1'b0, 1'b0, "R2");
        // R3: step pulse lasts one cycle
        drive_phase(1'b0, 1'b1, "R3");
        @(negedge clk);
        check_now(K_EN, 0, "R3");
        repeat (3) @(negedge clk);
        // R5: chatter on phase B
        drive_phase(1'b0, 1'b0, "R5");
        drive_phase(1'b0, 1'b1, "R5");
        drive_phase(1'b0, 1'b0, "R5");
        drive_phase(1'b0, 1'b1, "R5");
        // R11: unchanged sample
        drive_phase(1'b0, 1'b1, "R11");
        // R4: double-bit jump 01 -> 10
        drive_phase(1'b1, 1'b0, "R4");
        // R7: flag stays set across legal steps
        drive_phase(1'b0, 1'b0, "R7");
        drive_phase(1'b0, 1'b1, "R7");
        // R6: first index zeroes, later ones ignored
        pulse_index("R6");
        drive_phase(1'b1, 1'b1, "R6");
        drive_phase(1'b1, 1'b0, "R6");
        pulse_index("R6");
        // R7: clear
        clear_errors("R7");
        // R8: saturate the event counter
        for (int i = 0; i < CMAX + 3; i++) begin
            if (m_prev == 2'b10) drive_phase(1'b0, 1'b1, "R8");
            else drive_phase(1'b1, 1'b0, "R8");
        end
        clear_errors("R8");
        // R9: step forward past the largest positive value
        while (m_pos != 127) begin
            case (m_prev)
                2'b00:   drive_phase(1'b0, 1'b1, "R9");
                2'b01:   drive_phase(1'b1, 1'b1, "R9");
                2'b11:   drive_phase(1'b1, 1'b0, "R9");
                default: drive_phase(1'b0, 1'b0, "R9");
            endcase
        end
        case (m_prev)
            2'b00:   drive_phase(1'b0, 1'b1, "R9");
            2'b01:   drive_phase(1'b1, 1'b1, "R9");
            2'b11:   drive_phase(1'b1, 1'b0, "R9");
            default: drive_phase(1'b0, 1'b0, "R9");
        endcase
        check_now(K_POS, -128, "R9");

        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule